// File: doc/BRIEF.md
# Programmed IO Transfer FIFO

This block is the byte buffer that sits behind the data register of a small SCSI host adapter when the host moves bytes by programmed IO. Host writes to the data register land in a 16-entry FIFO, and host reads pull from it. The current fill count is driven out so that the flags register can show it. When the adapter is collecting a command, host writes go to a separate 16-byte command buffer instead. The command engine reads that buffer by index and empties it when it has used the command.

Reads depend on the bus phase supplied by the status logic. In the data-out phase a read returns zero and leaves the read pointer where it is. Any successful read raises an interrupt pulse. A write into a FIFO that already holds 15 bytes is refused and flagged. Each time the FIFO drains to empty, both pointers return to entry 0. The adapter can also preload a two-byte status response (a status code followed by a zero byte) that replaces the FIFO contents.

Top module: `pio_xfer_fifo`

## Requirements
- R1: After reset, count_o is 0, rd_data_o is 0x00, cmd_len_o is 0, and irq_o and ovr_o are low.
- R2: A write with cmd_mode_i low and the count below 15 stores the byte at the write pointer and adds one to the count. Reads outside the data-out phase return the bytes in the order they were written.
- R3: A write with cmd_mode_i low and the count equal to 15 is refused. The count and the stored bytes stay unchanged, and ovr_o is high for exactly the one cycle after the write.
- R4: A read while the count is above 0 lowers the count by one and makes irq_o high for the one cycle after the read.
- R5: A read taken while phase_i[2:1] is 00 (data-out) loads rd_data_o with 0x00 and leaves the read pointer unchanged. Any other value of phase_i[2:1] returns the byte at the read pointer and advances the pointer.
- R6: Whenever the count becomes 0, both the read pointer and the write pointer return to entry 0.
- R7: A read while the count is 0 leaves rd_data_o holding its previous value, leaves the count at 0, and raises no irq_o.
- R8: While rsp_load_i is high, entry 0 takes rsp_code_i and entry 1 takes 0x00. The count becomes 2, both pointers become 0, and irq_o pulses. Host reads and writes in that same cycle are dropped.
- R9: A write with cmd_mode_i high stores the byte in the command buffer at index cmd_len_o and adds one to cmd_len_o. The data FIFO and its count are not touched. cmd_data_o shows the command-buffer entry selected by cmd_idx_i.
- R10: A command write when cmd_len_o is 16 is dropped and ovr_o pulses for one cycle. While cmd_clr_i is high, cmd_len_o returns to 0 and command writes in that cycle are dropped.
- R11: A read and a data write in the same cycle both take effect, so the count is unchanged. The overrun test of R3 uses the count from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe for the data register |
| wr_data_i | input | 8 | Host write byte |
| rd_en_i | input | 1 | Host read strobe for the data register |
| rd_data_o | output | 8 | Data register read value, registered |
| phase_i | input | 3 | Current bus phase from status; [2:1]==00 is data-out |
| cmd_mode_i | input | 1 | Send host writes to the command buffer |
| cmd_clr_i | input | 1 | Empty the command buffer |
| cmd_idx_i | input | 4 | Command-buffer read index |
| cmd_data_o | output | 8 | Command-buffer entry at cmd_idx_i |
| cmd_len_o | output | 5 | Bytes held in the command buffer |
| rsp_load_i | input | 1 | Load the two-byte status response |
| rsp_code_i | input | 8 | Status code for the response |
| count_o | output | 5 | FIFO fill count, for the flags register |
| irq_o | output | 1 | One-cycle interrupt request |
| ovr_o | output | 1 | One-cycle overrun flag |

## Verification
A host read and a data write can fall in the same cycle. The read frees an entry and the write fills one. The bench provokes this on a FIFO that holds one byte, where the count must stay the same and the oldest byte must come out. It then provokes it on a full FIFO, where the write must still be refused because the count it sees is 15. The response load can also fall in the same cycle as a host write, and the bench checks that the response alone decides the count and the bytes that are read out next.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
  // phase_i[2:1] == 00 marks the data-out phase
  function automatic logic is_data_out(input logic [2:0] ph);
    return ph[2:1] == 2'b00;
  endfunction
endpackage

// File: rtl/pio_fifo_store.sv
module pio_fifo_store #(
  parameter int DEPTH  = 16,
  parameter int DW     = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rsp_i,
  input  logic [DW-1:0]    rsp_code_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (rsp_i && g < 2) begin
        mem_q[g] <= (g == 0) ? rsp_code_i : '0;
      end else if (we_i && waddr_i == PTR_W'(g)) begin
        mem_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pio_fifo_ctrl.sv
module pio_fifo_ctrl
  import pio_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int LIMIT = DEPTH - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic             cmd_mode_i,
  input  logic             rsp_load_i,
  input  logic [2:0]       phase_i,
  output logic             wr_ok_o,
  output logic             rd_ok_o,
  output logic             rd_zero_o,
  output logic             ovr_o,
  output logic [PTR_W-1:0] wptr_o,
  output logic [PTR_W-1:0] rptr_o,
  output logic [CNT_W-1:0] count_o
);
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             data_wr, full, rd_adv;

  assign data_wr   = wr_en_i && !cmd_mode_i && !rsp_load_i;
  assign full      = cnt_q == CNT_W'(LIMIT);
  assign wr_ok_o   = data_wr && !full;
  assign ovr_o     = data_wr && full;
  assign rd_ok_o   = rd_en_i && (cnt_q != '0) && !rsp_load_i;
  assign rd_zero_o = is_data_out(phase_i);
  assign rd_adv    = rd_ok_o && !rd_zero_o;
  assign cnt_d     = cnt_q + CNT_W'(wr_ok_o) - CNT_W'(rd_ok_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (rsp_load_i) begin
      cnt_q  <= CNT_W'(2);
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (cnt_d == '0) begin
        wptr_q <= '0;
        rptr_q <= '0;
      end else begin
        wptr_q <= wptr_q + PTR_W'(wr_ok_o);
        rptr_q <= rptr_q + PTR_W'(rd_adv);
      end
    end
  end

  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/pio_fifo_cmdbuf.sv
module pio_fifo_cmdbuf #(
  parameter int DEPTH  = 16,
  parameter int DW     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             clr_i,
  input  logic [PTR_W-1:0] idx_i,
  output logic [DW-1:0]    rdata_o,
  output logic [CNT_W-1:0] len_o,
  output logic             ovr_o
);
  logic [DW-1:0]    buf_q [DEPTH];
  logic [CNT_W-1:0] len_q;
  logic             store;

  assign store = wr_i && !clr_i && (len_q != CNT_W'(DEPTH));
  assign ovr_o = wr_i && !clr_i && (len_q == CNT_W'(DEPTH));

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) buf_q[g] <= '0;
      else if (store && len_q[PTR_W-1:0] == PTR_W'(g)) buf_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    len_q <= '0;
    else if (clr_i) len_q <= '0;
    else if (store) len_q <= len_q + 1'b1;
  end

  assign rdata_o = buf_q[idx_i];
  assign len_o   = len_q;
endmodule

// File: rtl/pio_xfer_fifo.sv
module pio_xfer_fifo #(
  parameter int DEPTH  = 16,
  parameter int DW     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_en_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic [2:0]       phase_i,
  input  logic             cmd_mode_i,
  input  logic             cmd_clr_i,
  input  logic [PTR_W-1:0] cmd_idx_i,
  output logic [DW-1:0]    cmd_data_o,
  output logic [CNT_W-1:0] cmd_len_o,
  input  logic             rsp_load_i,
  input  logic [DW-1:0]    rsp_code_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             ovr_o
);
  logic             wr_ok, rd_ok, rd_zero, data_ovr, cmd_ovr;
  logic [PTR_W-1:0] wptr, rptr;
  logic [DW-1:0]    mem_rd;
  logic [DW-1:0]    rd_q;
  logic             irq_q, ovr_q;

  pio_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .cmd_mode_i, .rsp_load_i, .phase_i,
    .wr_ok_o(wr_ok), .rd_ok_o(rd_ok), .rd_zero_o(rd_zero), .ovr_o(data_ovr),
    .wptr_o(wptr), .rptr_o(rptr), .count_o(count_o)
  );

  pio_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni, .we_i(wr_ok), .waddr_i(wptr), .wdata_i(wr_data_i),
    .rsp_i(rsp_load_i), .rsp_code_i(rsp_code_i), .raddr_i(rptr),
    .rdata_o(mem_rd)
  );

  pio_fifo_cmdbuf #(.DEPTH(DEPTH), .DW(DW)) u_cmd (
    .clk_i, .rst_ni, .wr_i(wr_en_i && cmd_mode_i), .wdata_i(wr_data_i),
    .clr_i(cmd_clr_i), .idx_i(cmd_idx_i), .rdata_o(cmd_data_o),
    .len_o(cmd_len_o), .ovr_o(cmd_ovr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (rd_ok) rd_q <= rd_zero ? '0 : mem_rd;
      irq_q <= rd_ok || rsp_load_i;
      ovr_q <= data_ovr || cmd_ovr;
    end
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq_q;
  assign ovr_o     = ovr_q;
endmodule

// File: rtl/pio_fifo_chk.sv
module pio_fifo_chk #(
  parameter int DEPTH  = 16,
  parameter int DW     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [DW-1:0]    rd_data_o,
  input logic [2:0]       phase_i,
  input logic             cmd_mode_i,
  input logic             cmd_clr_i,
  input logic [CNT_W-1:0] cmd_len_o,
  input logic             rsp_load_i,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             ovr_o
);
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH - 1));

  assert_full_write_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !cmd_mode_i && !rsp_load_i && !rd_en_i && count_o == CNT_W'(DEPTH - 1))
    |=> (ovr_o && count_o == CNT_W'(DEPTH - 1)));

  assert_read_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rsp_load_i && count_o != '0) |=> irq_o);

  assert_dataout_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rsp_load_i && count_o != '0 && phase_i[2:1] == 2'b00) |=> rd_data_o == '0);

  assert_empty_read_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && !rsp_load_i && count_o == '0) |=> ($stable(rd_data_o) && count_o == '0 && !irq_o));

  assert_rsp_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_load_i |=> (count_o == CNT_W'(2) && irq_o));

  assert_cmd_len_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_len_o <= CNT_W'(DEPTH));

  assert_cmd_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_clr_i |=> cmd_len_o == '0);
endmodule

bind pio_xfer_fifo pio_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .rd_data_o(rd_data_o), .phase_i(phase_i), .cmd_mode_i(cmd_mode_i),
  .cmd_clr_i(cmd_clr_i), .cmd_len_o(cmd_len_o), .rsp_load_i(rsp_load_i),
  .count_o(count_o), .irq_o(irq_o), .ovr_o(ovr_o)
);

// File: tb/pio_xfer_fifo_tb.sv
module pio_xfer_fifo_tb;
  localparam logic [2:0] PH_OUT = 3'b000;
  localparam logic [2:0] PH_IN  = 3'b111;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 0, rd_en = 0, cmd_mode = 0, cmd_clr = 0, rsp_load = 0;
  logic [7:0] wr_data = 0, rsp_code = 0;
  logic [2:0] phase = PH_IN;
  logic [3:0] cmd_idx = 0;
  logic [7:0] rd_data, cmd_data;
  logic [4:0] cmd_len, count;
  logic       irq, ovr;
  int         total = 0, bad = 0;

  always #10 clk = ~clk;

  pio_xfer_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .phase_i(phase),
    .cmd_mode_i(cmd_mode), .cmd_clr_i(cmd_clr), .cmd_idx_i(cmd_idx),
    .cmd_data_o(cmd_data), .cmd_len_o(cmd_len), .rsp_load_i(rsp_load),
    .rsp_code_i(rsp_code), .count_o(count), .irq_o(irq), .ovr_o(ovr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one clock with the given strobes, results sampled 1 ns after the edge
  task automatic cyc(input logic w, input logic [7:0] d, input logic r);
    wr_en = w; wr_data = d; rd_en = r;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 count", count, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 cmd_len", cmd_len, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ovr", ovr, 0);
  endtask

  task automatic t_order;
    phase = PH_IN;
    cyc(1, 8'h11, 0); cyc(1, 8'h22, 0); cyc(1, 8'h33, 0);
    chk("R2 count after 3 writes", count, 3);
    cyc(0, 0, 1);
    chk("R2 first byte", rd_data, 8'h11);
    chk("R4 irq on read", irq, 1);
    chk("R4 count after read", count, 2);
    cyc(0, 0, 1); chk("R2 second byte", rd_data, 8'h22);
    cyc(0, 0, 1); chk("R2 third byte", rd_data, 8'h33);
    chk("R4 count drained", count, 0);
    cyc(0, 0, 0); chk("R4 irq one cycle", irq, 0);
  endtask

  task automatic t_overrun;
    phase = PH_IN;
    for (int i = 0; i < 15; i++) cyc(1, 8'h40 + 8'(i), 0);
    chk("R3 count full", count, 15);
    chk("R3 no early ovr", ovr, 0);
    cyc(1, 8'hEE, 0);
    chk("R3 ovr pulse", ovr, 1);
    chk("R3 count held", count, 15);
    cyc(0, 0, 0);
    chk("R3 ovr one cycle", ovr, 0);
    for (int i = 0; i < 15; i++) begin
      cyc(0, 0, 1);
      chk("R3 stored data intact", rd_data, 8'h40 + 8'(i));
    end
    chk("R3 drained", count, 0);
  endtask

  task automatic t_dataout;
    phase = PH_IN;
    cyc(1, 8'h05, 0); cyc(1, 8'h06, 0); cyc(1, 8'h07, 0);
    phase = PH_OUT;
    cyc(0, 0, 1);
    chk("R5 data-out reads zero", rd_data, 0);
    chk("R5 count drops", count, 2);
    chk("R4 irq data-out read", irq, 1);
    phase = 3'b001;
    cyc(0, 0, 1);
    chk("R5 phase 001 also zero", rd_data, 0);
    phase = PH_IN;
    cyc(0, 0, 1);
    chk("R5 pointer not advanced", rd_data, 8'h05);
    chk("R5 count empty", count, 0);
  endtask

  task automatic t_ptr_reset;
    phase = PH_IN;
    cyc(1, 8'hA1, 0); cyc(1, 8'hB2, 0);
    phase = PH_OUT;
    cyc(0, 0, 1); cyc(0, 0, 1);
    chk("R6 emptied", count, 0);
    phase = PH_IN;
    cyc(1, 8'hC3, 0);
    cyc(0, 0, 1);
    chk("R6 pointers back to 0", rd_data, 8'hC3);
  endtask

  task automatic t_empty;
    logic [7:0] last;
    last = rd_data;
    cyc(0, 0, 1);
    chk("R7 empty read holds", rd_data, last);
    chk("R7 count stays 0", count, 0);
    chk("R7 no irq", irq, 0);
  endtask

  task automatic t_rsp;
    phase = PH_IN;
    cyc(1, 8'h71, 0); cyc(1, 8'h72, 0); cyc(1, 8'h73, 0);
    rsp_load = 1; rsp_code = 8'h5A;
    cyc(1, 8'h99, 1);
    rsp_load = 0;
    chk("R8 count 2", count, 2);
    chk("R8 irq", irq, 1);
    chk("R8 same-cycle read dropped", rd_data, 8'hC3);
    cyc(0, 0, 1); chk("R8 status byte", rd_data, 8'h5A);
    cyc(0, 0, 1); chk("R8 zero byte", rd_data, 8'h00);
    chk("R8 drained", count, 0);
  endtask

  task automatic t_cmd;
    cmd_mode = 1;
    cyc(1, 8'h12, 0); cyc(1, 8'h34, 0);
    cmd_mode = 0;
    chk("R9 cmd_len", cmd_len, 2);
    chk("R9 fifo untouched", count, 0);
    cmd_idx = 0; #1; chk("R9 cmd byte 0", cmd_data, 8'h12);
    cmd_idx = 1; #1; chk("R9 cmd byte 1", cmd_data, 8'h34);
  endtask

  task automatic t_cmd_full;
    cmd_clr = 1; cyc(0, 0, 0); cmd_clr = 0;
    chk("R10 clear", cmd_len, 0);
    cmd_mode = 1;
    for (int i = 0; i < 16; i++) cyc(1, 8'h80 + 8'(i), 0);
    chk("R10 cmd full", cmd_len, 16);
    chk("R10 no early ovr", ovr, 0);
    cyc(1, 8'hFF, 0);
    chk("R10 cmd ovr", ovr, 1);
    chk("R10 len held", cmd_len, 16);
    cmd_mode = 0;
    cmd_idx = 0;  #1; chk("R10 entry 0 intact", cmd_data, 8'h80);
    cmd_idx = 15; #1; chk("R10 entry 15", cmd_data, 8'h8F);
    cmd_mode = 1; cmd_clr = 1;
    cyc(1, 8'h55, 0);
    cmd_clr = 0; cmd_mode = 0;
    chk("R10 clear wins", cmd_len, 0);
    chk("R9 cmd writes skip fifo", count, 0);
  endtask

  task automatic t_simul;
    phase = PH_IN;
    cyc(1, 8'h61, 0);
    cyc(1, 8'h62, 1);
    chk("R11 count same", count, 1);
    chk("R11 read oldest", rd_data, 8'h61);
    chk("R11 no ovr", ovr, 0);
    for (int i = 0; i < 14; i++) cyc(1, 8'h90 + 8'(i), 0);
    chk("R11 full", count, 15);
    cyc(1, 8'hDD, 1);
    chk("R11 ovr on full", ovr, 1);
    chk("R11 count 14", count, 14);
    chk("R11 read ok", rd_data, 8'h62);
    for (int i = 0; i < 14; i++) begin
      cyc(0, 0, 1);
      chk("R11 remaining data", rd_data, 8'h90 + 8'(i));
    end
    chk("R11 drained", count, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_order();
        t_overrun();
        t_dataout();
        t_ptr_reset();
        t_empty();
        t_rsp();
        t_cmd();
        t_cmd_full();
        t_simul();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule